// File: doc/BRIEF.md
# End-of-Frame Status Flag and Interrupt Generator

This block keeps the display processor's end-of-frame flag and turns it into an interrupt for the host CPU. A one-cycle pulse marks the moment the last visible scanline has been drawn, and that pulse sets the flag. The flag is shown in bit 7 of the status byte. A read of the status register clears it. The interrupt enable sits in bit 5 of control register 1 and is loaded whenever that register is written.

The interrupt line is simply the enable ANDed with the flag. The flag is set whether or not interrupts are enabled, so turning the enable on while a frame end is still unread raises the line straight away. On the CPU side, an edge detector turns each rise of that line into one single-clock non-maskable interrupt pulse. A line that stays high produces no further pulses. The other status bits (collisions, sprite overflow) do not belong to this block and always read as zero.

Top module: `frame_irq_unit`

## Requirements
- R1: A `frame_end` pulse sets the frame flag. The next status read returns bit 7 (value 0x80) set.
- R2: A status read clears the flag. The byte it returns carries the flag value from before the clear in bit 7, and bits 6..0 are always zero. `status_byte` is loaded in the clock after the `status_rd` strobe and keeps its value until the next strobe.
- R3: `irq_line` is high exactly when the enable bit and the frame flag are both set. A status read with no frame end in the same cycle drops it in the next cycle.
- R4: While the enable is clear, the flag still sets on `frame_end` and `irq_line` stays low.
- R5: If register 1 is written with bit 5 set while the flag is already set, `irq_line` goes high in the next cycle.
- R6: `nmi_pulse` is high for exactly one clock, one cycle after each low-to-high change of `irq_line`. While `irq_line` stays high, no further pulse occurs.
- R7: When `frame_end` and `status_rd` come in the same cycle, the flag ends up set, and the returned bit 7 holds the value from before that cycle.
- R8: Only a write with `reg_addr` equal to 1 changes the enable, and it takes `reg_data` bit 5. Writes to any other address have no effect on it.
- R9: Reset clears the flag, the enable and the edge-detector history. `status_byte`, `irq_line` and `nmi_pulse` are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | Pulse: last visible scanline finished |
| status_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Control register write strobe |
| reg_addr | input | 3 | Control register index |
| reg_data | input | 8 | Control register write data |
| status_byte | output | 8 | Status byte captured at the last read |
| irq_line | output | 1 | Level interrupt request |
| nmi_pulse | output | 1 | One-clock NMI event to the CPU |

## Verification
The assertions check the following on every cycle:
- the NMI appears one cycle after each rise of the interrupt line, and it never lasts two cycles;
- the line falls after a status read that has no frame end beside it;
- a frame end followed by a read returns bit 7 set;
- writing bit 5 of register 1 as zero drops the line;
- the unused status bits stay at zero.

Some behaviours can only be shown by the bench's scenarios, because they depend on the hidden flag and enable state across several steps:
- the flag keeps its value while the enable is off;
- enabling the interrupt late fires it at once;
- writes to other registers are ignored;
- a frame end and a read in the same cycle resolve as R7 describes.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
  localparam int unsigned BUS_W_DEF   = 8;
  localparam int unsigned ADDR_W_DEF  = 3;
  localparam int unsigned CTRL_IDX    = 1;
  localparam int unsigned EN_BIT_DEF  = 5;
  localparam int unsigned FLAG_BIT_DEF = 7;

  typedef struct packed {
    logic flag;
    logic snap;
  } flag_state_t;
endpackage

// File: rtl/frame_flag_reg.sv
module frame_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic snap_o
);
  import frame_irq_pkg::*;
  flag_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      if (clr_i) st_q.snap <= st_q.flag;
      if (set_i)      st_q.flag <= 1'b1;
      else if (clr_i) st_q.flag <= 1'b0;
    end
  end

  assign flag_o = st_q.flag;
  assign snap_o = st_q.snap;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned REG_IDX = 1,
  parameter int unsigned EN_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic              en_o
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_IDX);
  logic hit;
  assign hit = wr_i && (addr_i == MATCH);

  always_ff @(posedge clk) begin
    if (rst)      en_o <= 1'b0;
    else if (hit) en_o <= data_i[EN_BIT];
  end
endmodule

// File: rtl/nmi_edge_gen.sv
module nmi_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      prev_q  <= level_i;
      pulse_o <= level_i && !prev_q;
    end
  end
endmodule

// File: rtl/frame_irq_unit.sv
module frame_irq_unit #(
  parameter int unsigned BUS_W    = frame_irq_pkg::BUS_W_DEF,
  parameter int unsigned ADDR_W   = frame_irq_pkg::ADDR_W_DEF,
  parameter int unsigned REG_IDX  = frame_irq_pkg::CTRL_IDX,
  parameter int unsigned EN_BIT   = frame_irq_pkg::EN_BIT_DEF,
  parameter int unsigned FLAG_BIT = frame_irq_pkg::FLAG_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic              status_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_data,
  output logic [BUS_W-1:0]  status_byte,
  output logic              irq_line,
  output logic              nmi_pulse
);
  logic flag;
  logic snap;
  logic irq_en;

  frame_flag_reg u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (frame_end),
    .clr_i  (status_rd),
    .flag_o (flag),
    .snap_o (snap)
  );

  irq_enable_reg #(
    .BUS_W   (BUS_W),
    .ADDR_W  (ADDR_W),
    .REG_IDX (REG_IDX),
    .EN_BIT  (EN_BIT)
  ) u_en (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (reg_wr),
    .addr_i (reg_addr),
    .data_i (reg_data),
    .en_o   (irq_en)
  );

  assign irq_line = irq_en && flag;

  nmi_edge_gen u_nmi (
    .clk     (clk),
    .rst     (rst),
    .level_i (irq_line),
    .pulse_o (nmi_pulse)
  );

  for (genvar b = 0; b < BUS_W; b++) begin : g_stat
    if (b == FLAG_BIT) begin : g_flag
      assign status_byte[b] = snap;
    end else begin : g_zero
      assign status_byte[b] = 1'b0;
    end
  end
endmodule

// File: rtl/frame_irq_checker.sv
module frame_irq_checker #(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned REG_IDX  = 1,
  parameter int unsigned EN_BIT   = 5,
  parameter int unsigned FLAG_BIT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_end,
  input logic              status_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BUS_W-1:0]  reg_data,
  input logic [BUS_W-1:0]  status_byte,
  input logic              irq_line,
  input logic              nmi_pulse
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_IDX);
  localparam logic [BUS_W-1:0] FLAG_MASK = BUS_W'(1) << FLAG_BIT;

  assert_frame_then_read_R1: assert property (@(posedge clk) disable iff (rst)
    (status_rd && $past(frame_end) && !$past(status_rd)) |=> status_byte[FLAG_BIT]);

  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (status_byte & ~FLAG_MASK) == '0);

  assert_read_drops_line_R3: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !frame_end) |=> !irq_line);

  assert_nmi_follows_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_line) |=> nmi_pulse);

  assert_nmi_one_clock_R6: assert property (@(posedge clk) disable iff (rst)
    nmi_pulse |=> !nmi_pulse);

  assert_disable_drops_line_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == MATCH && !reg_data[EN_BIT]) |=> !irq_line);

  assert_reset_clean_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_line && !nmi_pulse && status_byte == '0));
endmodule

bind frame_irq_unit frame_irq_checker #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .REG_IDX(REG_IDX), .EN_BIT(EN_BIT), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk(clk), .rst(rst), .frame_end(frame_end), .status_rd(status_rd),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
  .status_byte(status_byte), .irq_line(irq_line), .nmi_pulse(nmi_pulse)
);

// File: tb/frame_irq_unit_bench.sv
module frame_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_end = 1'b0;
  logic       status_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_data = '0;
  logic [7:0] status_byte;
  logic       irq_line;
  logic       nmi_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frame_irq_unit u_frame_irq_unit (
    .clk(clk), .rst(rst), .frame_end(frame_end), .status_rd(status_rd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
    .status_byte(status_byte), .irq_line(irq_line), .nmi_pulse(nmi_pulse)
  );

  // behavioural reference
  bit m_flag, m_en, m_prev, m_nmi;
  int m_stat;
  always @(posedge clk) begin
    if (rst) begin
      m_flag <= 0; m_en <= 0; m_prev <= 0; m_nmi <= 0; m_stat <= 0;
    end else begin
      if (status_rd) m_stat <= m_flag ? 128 : 0;
      m_flag <= frame_end ? 1'b1 : (status_rd ? 1'b0 : m_flag);
      if (reg_wr && reg_addr == 3'd1) m_en <= reg_data[5];
      m_prev <= m_en && m_flag;
      m_nmi  <= (m_en && m_flag) && !m_prev;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 status_byte model", int'(status_byte), m_stat);
      chk("R3 irq_line model", int'(irq_line), int'(m_en && m_flag));
      chk("R6 nmi_pulse model", int'(nmi_pulse), int'(m_nmi));
    end
  end

  task automatic drive(bit fe, bit rd, bit wr, int addr, int data);
    @(negedge clk);
    frame_end = fe; status_rd = rd; reg_wr = wr;
    reg_addr = 3'(addr); reg_data = 8'(data);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 status after reset", int'(status_byte), 0);
    chk("R9 irq after reset", int'(irq_line), 0);
    chk("R9 nmi after reset", int'(nmi_pulse), 0);
    // R4 / R1 / R2
    drive(1, 0, 0, 0, 0); idle();
    chk("R4 irq masked", int'(irq_line), 0);
    drive(0, 1, 0, 0, 0); idle();
    chk("R1 flag read", int'(status_byte), 128);
    drive(0, 1, 0, 0, 0); idle();
    chk("R2 cleared read", int'(status_byte), 0);
    // R8 / R5 / R6
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 1, 2, 8'h20); idle();
    chk("R8 other addr ignored", int'(irq_line), 0);
    drive(0, 0, 1, 1, 8'h20); idle();
    chk("R5 late enable fires", int'(irq_line), 1);
    chk("R6 nmi not yet", int'(nmi_pulse), 0);
    idle();
    chk("R6 nmi pulse", int'(nmi_pulse), 1);
    idle();
    chk("R6 nmi one clock", int'(nmi_pulse), 0);
    drive(1, 0, 0, 0, 0); idle();
    chk("R6 no retrigger", int'(nmi_pulse), 0);
    idle();
    chk("R6 no retrigger later", int'(nmi_pulse), 0);
    // R3
    drive(0, 1, 0, 0, 0); idle();
    chk("R3 read drops irq", int'(irq_line), 0);
    chk("R2 old value returned", int'(status_byte), 128);
    drive(1, 0, 0, 0, 0); idle();
    chk("R3 irq back", int'(irq_line), 1);
    idle();
    chk("R6 second nmi", int'(nmi_pulse), 1);
    // R7
    drive(0, 1, 0, 0, 0); idle();
    drive(1, 1, 0, 0, 0); idle();
    chk("R7 read returns old", int'(status_byte), 0);
    chk("R7 flag stays set", int'(irq_line), 1);
    drive(0, 1, 0, 0, 0); idle();
    chk("R7 next read", int'(status_byte), 128);
    // R4 again with enable cleared
    drive(0, 0, 1, 1, 8'h00);
    drive(1, 0, 0, 0, 0); idle();
    chk("R4 irq low while disabled", int'(irq_line), 0);
    drive(0, 1, 0, 0, 0); idle();
    chk("R4 flag set while disabled", int'(status_byte), 128);
    repeat (3) idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule